// File: doc/BRIEF.md
# In-order memory operation scan queue

This block sits between dispatch and the data cache probe path. Dispatch places load and store operations into a twelve-slot circular queue in program order, up to two per cycle. Each operation records whether it is a load or a store and whether it is 32 or 64 bits wide. The slot index it lands in is its tag. The two address-generation ports compute addresses later and in any order, and write them back into the queue by tag. So the queue acts as an address reorder buffer.

Each cycle the block looks at the two oldest unissued operations. It scans out the oldest one once its address is present. The second-oldest one goes with it when its address is also present and the pair is legal. A legal pair is two loads, a load and a store in either order, or two stores that are both 32 bits. Scanned operations free their slots at once and then travel through a two-stage probe delay line (address transport, then cache access). They come out at the access-stage outputs, with lane 0 always carrying the older operation. A flush input empties the queue and the delay line in one cycle.

Top module: `memop_scan_queue`

## Requirements
- R1: After reset the queue is empty. Both access lanes are invalid. A two-operation dispatch is accepted without stall and receives tags 0 and 1.
- R2: Tags are slot indices handed out in program order and wrap from DEPTH-1 back to 0. A requesting lane 0 takes the current tail. A requesting lane 1 takes the slot after lane 0's, or the tail when lane 0 is idle.
- R3: `disp_stall` is 1 exactly when the number of requesting lanes exceeds the free slots at the start of the cycle. A stalled dispatch allocates nothing.
- R4: An address write stores the address into the slot named by its tag only if that slot holds a queued, unissued operation. Writes to free or just-scanned slots are ignored. A newly allocated slot always starts without an address. When both ports write the same tag in one cycle, port 1's address is kept. A written address can be scanned from the next cycle on.
- R5: Nothing is scanned in a cycle where the oldest queued operation has no address, whatever the state of younger operations.
- R6: The second-oldest operation is scanned together with the oldest only if it has an address and the pair is allowed. The encoding is `store`=1 for a store and 0 for a load, and `is64`=1 for 64 bits and 0 for 32 bits. Allowed pairs are load+load of any size, load and store in either order of any size, and store+store only when both are 32 bits.
- R7: A slot scanned in a cycle is free for dispatch from the following cycle. Its release does not count as room for a dispatch in the scan cycle itself.
- R8: An operation scanned in cycle N appears on the `acc_*` outputs in cycle N+2 with its type, size, address and tag. When two operations issue together, lane 0 carries the older one.
- R9: A flush empties the queue and both probe stages in one cycle. A dispatch in the flush cycle is discarded. The next dispatch receives tag 0.
- R10: At most two operations leave per cycle, never out of program order. Lane 1 is never valid without lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empties queue and probe stages |
| disp_req | input | 2 | Dispatch request per lane, lane 0 older |
| disp_store | input | 2 | Per lane: 1 store, 0 load |
| disp_is64 | input | 2 | Per lane: 1 for 64-bit, 0 for 32-bit |
| disp_tag | output | 2 x TAG_W | Slot tag given to each requesting lane |
| disp_stall | output | 1 | Not enough free slots; nothing allocated |
| agu_we | input | 2 | Address write enable per AGU port |
| agu_tag | input | 2 x TAG_W | Target slot per AGU port |
| agu_addr | input | 2 x ADDR_W | Address per AGU port |
| acc_vld | output | 2 | Access-stage valid per lane |
| acc_store | output | 2 | Access-stage operation type per lane |
| acc_is64 | output | 2 | Access-stage size per lane |
| acc_addr | output | 2 x ADDR_W | Access-stage address per lane |
| acc_tag | output | 2 x TAG_W | Access-stage tag per lane |

## Verification
The bench keeps the default depth of twelve and narrows addresses to 16 bits. With the real depth, a full queue, a stall caused by a single missing slot, and tag wrap from 11 back to 0 are all reached in a few dozen cycles. Directed phases cover every store/load pairing, the case where a younger address arrives first, port priority on a shared tag, writes to unallocated slots, and a flush that lands while the probe stages are busy. A long seeded mixed phase then interleaves flushes, partial dispatches and out-of-order address writes against the behavioural model.

// File: rtl/msq_pkg.sv
package msq_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_kind_e;

  // Two stores may share a cycle only when both are narrow.
  function automatic logic pair_allowed(op_kind_e k_old, logic w_old,
                                        op_kind_e k_young, logic w_young);
    if (k_old == OP_STORE && k_young == OP_STORE) begin
      return !w_old && !w_young;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/msq_rst_sync.sv
module msq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/msq_alloc.sv
module msq_alloc #(
  parameter int DEPTH = 12,
  parameter int PTR_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       req,
  input  logic [1:0]       n_issue,
  output logic [PTR_W-1:0] tag0,
  output logic [PTR_W-1:0] tag1,
  output logic             stall,
  output logic [1:0]       grant
);

  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic [CNT_W:0]   free_cnt;
  logic [1:0]       n_req;
  logic [1:0]       n_grant;

  function automatic logic [PTR_W-1:0] ptr_add(logic [PTR_W-1:0] p, logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    n_req    = {1'b0, req[0]} + {1'b0, req[1]};
    free_cnt = (CNT_W+1)'(DEPTH) - {1'b0, occ_q};
    stall    = (CNT_W+1)'(n_req) > free_cnt;
    grant    = (stall || flush) ? 2'b00 : req;
    n_grant  = {1'b0, grant[0]} + {1'b0, grant[1]};
    tag0     = tail_q;
    tag1     = req[0] ? ptr_add(tail_q, 2'd1) : tail_q;
    if (flush) begin
      tail_d = '0;
      occ_d  = '0;
    end else begin
      tail_d = ptr_add(tail_q, n_grant);
      occ_d  = occ_q + CNT_W'(n_grant) - CNT_W'(n_issue);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

endmodule

// File: rtl/msq_entries.sv
module msq_entries #(
  parameter int DEPTH  = 12,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [1:0]                   alloc_grant,
  input  logic [1:0][PTR_W-1:0]        alloc_tag,
  input  logic [1:0]                   alloc_store,
  input  logic [1:0]                   alloc_is64,
  input  logic [1:0]                   agu_we,
  input  logic [1:0][PTR_W-1:0]        agu_tag,
  input  logic [1:0][ADDR_W-1:0]       agu_addr,
  input  logic [DEPTH-1:0]             release_vec,
  output logic [DEPTH-1:0]             ent_vld,
  output logic [DEPTH-1:0]             ent_aval,
  output logic [DEPTH-1:0]             ent_store,
  output logic [DEPTH-1:0]             ent_is64,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              vld_q, vld_d;
    logic              aval_q, aval_d;
    logic              st_q, st_d;
    logic              big_q, big_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              hit_a0, hit_a1, hit_w0, hit_w1;
    logic              kind_en, addr_en;

    always_comb begin
      hit_a0  = alloc_grant[0] && (alloc_tag[0] == PTR_W'(g));
      hit_a1  = alloc_grant[1] && (alloc_tag[1] == PTR_W'(g));
      hit_w0  = agu_we[0] && (agu_tag[0] == PTR_W'(g)) && vld_q && !release_vec[g];
      hit_w1  = agu_we[1] && (agu_tag[1] == PTR_W'(g)) && vld_q && !release_vec[g];
      kind_en = hit_a0 || hit_a1;
      st_d    = hit_a1 ? alloc_store[1] : alloc_store[0];
      big_d   = hit_a1 ? alloc_is64[1]  : alloc_is64[0];
      addr_en = hit_w0 || hit_w1;
      addr_d  = hit_w1 ? agu_addr[1] : agu_addr[0];
      vld_d   = vld_q;
      aval_d  = aval_q;
      if (release_vec[g]) begin
        vld_d  = 1'b0;
        aval_d = 1'b0;
      end
      if (addr_en) aval_d = 1'b1;
      if (kind_en) begin
        vld_d  = 1'b1;
        aval_d = 1'b0;
      end
      if (flush) begin
        vld_d  = 1'b0;
        aval_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        aval_q <= 1'b0;
      end else begin
        vld_q  <= vld_d;
        aval_q <= aval_d;
      end
    end

    always_ff @(posedge clk) begin
      if (kind_en) begin
        st_q  <= st_d;
        big_q <= big_d;
      end
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end

    assign ent_vld[g]   = vld_q;
    assign ent_aval[g]  = aval_q;
    assign ent_store[g] = st_q;
    assign ent_is64[g]  = big_q;
    assign ent_addr[g]  = addr_q;
  end

endmodule

// File: rtl/msq_scan_sel.sv
module msq_scan_sel
  import msq_pkg::*;
#(
  parameter int DEPTH  = 12,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [DEPTH-1:0]             ent_vld,
  input  logic [DEPTH-1:0]             ent_aval,
  input  logic [DEPTH-1:0]             ent_store,
  input  logic [DEPTH-1:0]             ent_is64,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [1:0]                   scan_vld,
  output logic [1:0]                   scan_store,
  output logic [1:0]                   scan_is64,
  output logic [1:0][ADDR_W-1:0]       scan_addr,
  output logic [1:0][PTR_W-1:0]        scan_tag,
  output logic [1:0]                   n_issue,
  output logic [DEPTH-1:0]             release_vec
);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] h0, h1;
  logic             rdy0, rdy1;

  function automatic logic [PTR_W-1:0] ptr_add(logic [PTR_W-1:0] p, logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    h0   = head_q;
    h1   = ptr_add(head_q, 2'd1);
    rdy0 = ent_vld[h0] && ent_aval[h0];
    rdy1 = ent_vld[h1] && ent_aval[h1];
    scan_vld[0] = !flush && rdy0;
    scan_vld[1] = scan_vld[0] && rdy1 &&
                  pair_allowed(op_kind_e'(ent_store[h0]), ent_is64[h0],
                               op_kind_e'(ent_store[h1]), ent_is64[h1]);
    scan_store   = {ent_store[h1], ent_store[h0]};
    scan_is64    = {ent_is64[h1], ent_is64[h0]};
    scan_addr[0] = ent_addr[h0];
    scan_addr[1] = ent_addr[h1];
    scan_tag[0]  = h0;
    scan_tag[1]  = h1;
    n_issue      = {1'b0, scan_vld[0]} + {1'b0, scan_vld[1]};
    release_vec  = '0;
    if (scan_vld[0]) release_vec[h0] = 1'b1;
    if (scan_vld[1]) release_vec[h1] = 1'b1;
    head_d = flush ? '0 : ptr_add(head_q, n_issue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else begin
      head_q <= head_d;
    end
  end

endmodule

// File: rtl/msq_probe_pipe.sv
module msq_probe_pipe #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [1:0]             in_vld,
  input  logic [1:0]             in_store,
  input  logic [1:0]             in_is64,
  input  logic [1:0][ADDR_W-1:0] in_addr,
  input  logic [1:0][TAG_W-1:0]  in_tag,
  output logic [1:0]             out_vld,
  output logic [1:0]             out_store,
  output logic [1:0]             out_is64,
  output logic [1:0][ADDR_W-1:0] out_addr,
  output logic [1:0][TAG_W-1:0]  out_tag
);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic              xp_v_q, xp_v_d, ac_v_q, ac_v_d;
    logic              xp_st_q, xp_big_q, ac_st_q, ac_big_q;
    logic [ADDR_W-1:0] xp_a_q, ac_a_q;
    logic [TAG_W-1:0]  xp_t_q, ac_t_q;

    always_comb begin
      xp_v_d = in_vld[l] && !flush;
      ac_v_d = xp_v_q && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xp_v_q <= 1'b0;
        ac_v_q <= 1'b0;
      end else begin
        xp_v_q <= xp_v_d;
        ac_v_q <= ac_v_d;
      end
    end

    always_ff @(posedge clk) begin
      if (xp_v_d) begin
        xp_st_q  <= in_store[l];
        xp_big_q <= in_is64[l];
        xp_a_q   <= in_addr[l];
        xp_t_q   <= in_tag[l];
      end
      if (ac_v_d) begin
        ac_st_q  <= xp_st_q;
        ac_big_q <= xp_big_q;
        ac_a_q   <= xp_a_q;
        ac_t_q   <= xp_t_q;
      end
    end

    assign out_vld[l]   = ac_v_q;
    assign out_store[l] = ac_st_q;
    assign out_is64[l]  = ac_big_q;
    assign out_addr[l]  = ac_a_q;
    assign out_tag[l]   = ac_t_q;
  end

endmodule

// File: rtl/memop_scan_queue.sv
module memop_scan_queue #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [1:0]             disp_req,
  input  logic [1:0]             disp_store,
  input  logic [1:0]             disp_is64,
  output logic [1:0][TAG_W-1:0]  disp_tag,
  output logic                   disp_stall,
  input  logic [1:0]             agu_we,
  input  logic [1:0][TAG_W-1:0]  agu_tag,
  input  logic [1:0][ADDR_W-1:0] agu_addr,
  output logic [1:0]             acc_vld,
  output logic [1:0]             acc_store,
  output logic [1:0]             acc_is64,
  output logic [1:0][ADDR_W-1:0] acc_addr,
  output logic [1:0][TAG_W-1:0]  acc_tag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                         rst_sync_n;
  logic [1:0]                   grant;
  logic [1:0]                   n_issue;
  logic [TAG_W-1:0]             tag0, tag1;
  logic [DEPTH-1:0]             ent_vld, ent_aval, ent_store, ent_is64;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0]             release_vec;
  logic [1:0]                   scan_vld, scan_store, scan_is64;
  logic [1:0][ADDR_W-1:0]       scan_addr;
  logic [1:0][TAG_W-1:0]        scan_tag;
  logic [1:0][TAG_W-1:0]        alloc_tag;

  msq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  msq_alloc #(.DEPTH(DEPTH), .PTR_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flush   (flush),
    .req     (disp_req),
    .n_issue (n_issue),
    .tag0    (tag0),
    .tag1    (tag1),
    .stall   (disp_stall),
    .grant   (grant)
  );

  assign alloc_tag[0] = tag0;
  assign alloc_tag[1] = tag1;
  assign disp_tag     = alloc_tag;

  msq_entries #(.DEPTH(DEPTH), .PTR_W(TAG_W), .ADDR_W(ADDR_W)) u_entries (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flush       (flush),
    .alloc_grant (grant),
    .alloc_tag   (alloc_tag),
    .alloc_store (disp_store),
    .alloc_is64  (disp_is64),
    .agu_we      (agu_we),
    .agu_tag     (agu_tag),
    .agu_addr    (agu_addr),
    .release_vec (release_vec),
    .ent_vld     (ent_vld),
    .ent_aval    (ent_aval),
    .ent_store   (ent_store),
    .ent_is64    (ent_is64),
    .ent_addr    (ent_addr)
  );

  msq_scan_sel #(.DEPTH(DEPTH), .PTR_W(TAG_W), .ADDR_W(ADDR_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flush       (flush),
    .ent_vld     (ent_vld),
    .ent_aval    (ent_aval),
    .ent_store   (ent_store),
    .ent_is64    (ent_is64),
    .ent_addr    (ent_addr),
    .scan_vld    (scan_vld),
    .scan_store  (scan_store),
    .scan_is64   (scan_is64),
    .scan_addr   (scan_addr),
    .scan_tag    (scan_tag),
    .n_issue     (n_issue),
    .release_vec (release_vec)
  );

  msq_probe_pipe #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .in_vld    (scan_vld),
    .in_store  (scan_store),
    .in_is64   (scan_is64),
    .in_addr   (scan_addr),
    .in_tag    (scan_tag),
    .out_vld   (acc_vld),
    .out_store (acc_store),
    .out_is64  (acc_is64),
    .out_addr  (acc_addr),
    .out_tag   (acc_tag)
  );

endmodule

// File: rtl/msq_checker.sv
module msq_checker #(
  parameter int DEPTH = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic [1:0] disp_req,
  input logic       disp_stall,
  input logic [1:0] scan_vld,
  input logic [1:0] scan_store,
  input logic [1:0] scan_is64,
  input logic [1:0] acc_vld
);

  int n_req;
  int n_out;
  int occ_q;

  always_comb begin
    n_req = int'(disp_req[0]) + int'(disp_req[1]);
    n_out = int'(scan_vld[0]) + int'(scan_vld[1]);
  end

  // Independent occupancy tally built from the block's edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 0;
    end else if (flush) begin
      occ_q <= 0;
    end else begin
      occ_q <= occ_q - n_out + ((!disp_stall) ? n_req : 0);
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= DEPTH);

  assert_stall_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> (occ_q + n_req > DEPTH));

  assert_room_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_stall) |-> (occ_q + n_req <= DEPTH));

  assert_lane_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_vld[1] |-> scan_vld[0]);

  assert_store_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld == 2'b11 && scan_store == 2'b11) |-> (scan_is64 == 2'b00));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (acc_vld == 2'b00 && scan_vld == 2'b00));

  assert_probe_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush ##1 !flush) |=> (acc_vld == $past(scan_vld, 2)));

endmodule

bind memop_scan_queue msq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .flush      (flush),
  .disp_req   (disp_req),
  .disp_stall (disp_stall),
  .scan_vld   (scan_vld),
  .scan_store (scan_store),
  .scan_is64  (scan_is64),
  .acc_vld    (acc_vld)
);

// File: tb/memop_scan_queue_tb.sv
module memop_scan_queue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 12;
  localparam int ADDR_W     = 16;
  localparam int TAG_W      = 4;

  logic                   clk;
  logic                   rst_n;
  logic                   flush;
  logic [1:0]             disp_req, disp_store, disp_is64;
  logic [1:0][TAG_W-1:0]  disp_tag;
  logic                   disp_stall;
  logic [1:0]             agu_we;
  logic [1:0][TAG_W-1:0]  agu_tag;
  logic [1:0][ADDR_W-1:0] agu_addr;
  logic [1:0]             acc_vld, acc_store, acc_is64;
  logic [1:0][ADDR_W-1:0] acc_addr;
  logic [1:0][TAG_W-1:0]  acc_tag;

  memop_scan_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_req(disp_req), .disp_store(disp_store), .disp_is64(disp_is64),
    .disp_tag(disp_tag), .disp_stall(disp_stall),
    .agu_we(agu_we), .agu_tag(agu_tag), .agu_addr(agu_addr),
    .acc_vld(acc_vld), .acc_store(acc_store), .acc_is64(acc_is64),
    .acc_addr(acc_addr), .acc_tag(acc_tag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk;
  int    n_fail;
  string cur_req;

  // Reference model state
  int          m_q[$];
  bit          m_inq[DEPTH];
  bit          m_av[DEPTH];
  bit          m_st[DEPTH];
  bit          m_big[DEPTH];
  logic [15:0] m_addr[DEPTH];
  int          m_tail;
  bit          p1_v[2], p1_st[2], p1_big[2], p2_v[2], p2_st[2], p2_big[2];
  logic [15:0] p1_a[2], p2_a[2];
  int          p1_t[2], p2_t[2];

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic idle();
    flush = 1'b0; disp_req = 2'b00; disp_store = 2'b00; disp_is64 = 2'b00;
    agu_we = 2'b00; agu_tag = '0; agu_addr = '0;
  endtask

  task automatic wr(int p, int tag, logic [15:0] a);
    agu_we[p]   = 1'b1;
    agu_tag[p]  = TAG_W'(tag);
    agu_addr[p] = a;
  endtask

  task automatic model_clear();
    m_q.delete();
    for (int i = 0; i < DEPTH; i++) begin
      m_inq[i] = 0; m_av[i] = 0;
    end
    m_tail = 0;
  endtask

  // Compare this cycle's outputs, advance the model across the next edge.
  task automatic cycle();
    int nreq, free_n, t0, t1;
    bit stall_e, iss0, iss1;
    #1;
    nreq    = int'(disp_req[0]) + int'(disp_req[1]);
    free_n  = DEPTH - m_q.size();
    stall_e = nreq > free_n;
    chk(cur_req, "disp_stall", 64'(disp_stall), 64'(stall_e));
    if (nreq > 0 && !stall_e && !flush) begin
      if (disp_req[0]) chk(cur_req, "tag lane0", 64'(disp_tag[0]), 64'(m_tail));
      if (disp_req[1]) chk(cur_req, "tag lane1", 64'(disp_tag[1]),
                           64'(disp_req[0] ? (m_tail + 1) % DEPTH : m_tail));
    end
    chk(cur_req, "acc_vld", 64'(acc_vld), 64'({p2_v[1], p2_v[0]}));
    for (int l = 0; l < 2; l++) begin
      if (p2_v[l]) begin
        chk(cur_req, "acc_store", 64'(acc_store[l]), 64'(p2_st[l]));
        chk(cur_req, "acc_is64", 64'(acc_is64[l]), 64'(p2_big[l]));
        chk(cur_req, "acc_addr", 64'(acc_addr[l]), 64'(p2_a[l]));
        chk(cur_req, "acc_tag", 64'(acc_tag[l]), 64'(p2_t[l]));
      end
    end
    iss0 = 0; iss1 = 0; t0 = 0; t1 = 0;
    if (!flush && m_q.size() > 0) begin
      t0   = m_q[0];
      iss0 = m_av[t0];
      if (iss0 && m_q.size() > 1) begin
        t1   = m_q[1];
        iss1 = m_av[t1] && !(m_st[t0] && m_st[t1] && (m_big[t0] || m_big[t1]));
      end
    end
    for (int l = 0; l < 2; l++) begin
      p2_v[l] = p1_v[l]; p2_st[l] = p1_st[l]; p2_big[l] = p1_big[l];
      p2_a[l] = p1_a[l]; p2_t[l] = p1_t[l];
    end
    p1_v[0] = iss0; p1_st[0] = m_st[t0]; p1_big[0] = m_big[t0]; p1_a[0] = m_addr[t0]; p1_t[0] = t0;
    p1_v[1] = iss1; p1_st[1] = m_st[t1]; p1_big[1] = m_big[t1]; p1_a[1] = m_addr[t1]; p1_t[1] = t1;
    if (flush) begin
      model_clear();
      for (int l = 0; l < 2; l++) begin
        p1_v[l] = 0; p2_v[l] = 0;
      end
    end else begin
      if (iss0) begin void'(m_q.pop_front()); m_inq[t0] = 0; m_av[t0] = 0; end
      if (iss1) begin void'(m_q.pop_front()); m_inq[t1] = 0; m_av[t1] = 0; end
      for (int p = 0; p < 2; p++) begin
        if (agu_we[p] && int'(agu_tag[p]) < DEPTH && m_inq[agu_tag[p]]) begin
          m_av[agu_tag[p]]   = 1;
          m_addr[agu_tag[p]] = agu_addr[p];
        end
      end
      if (!stall_e) begin
        for (int l = 0; l < 2; l++) begin
          if (disp_req[l]) begin
            m_q.push_back(m_tail);
            m_inq[m_tail] = 1; m_av[m_tail] = 0;
            m_st[m_tail] = disp_store[l]; m_big[m_tail] = disp_is64[l];
            m_tail = (m_tail + 1) % DEPTH;
          end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic pair_case(bit s0, bit b0, bit s1, bit b1, logic [15:0] a);
    int base;
    base = m_tail;
    idle(); disp_req = 2'b11; disp_store = {s1, s0}; disp_is64 = {b1, b0};
    cycle();
    idle(); wr(0, base, a); wr(1, (base + 1) % DEPTH, a + 16'h10);
    cycle();
    idle();
    repeat (5) cycle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    int t;
    n_chk = 0; n_fail = 0; cur_req = "R1";
    model_clear();
    for (int l = 0; l < 2; l++) begin
      p1_v[l] = 0; p2_v[l] = 0;
    end
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle();

    // R1: empty after reset, first pair gets tags 0 and 1
    disp_req = 2'b11; disp_is64 = 2'b11;
    #1;
    chk("R1", "reset acc_vld", 64'(acc_vld), 64'd0);
    chk("R1", "reset stall", 64'(disp_stall), 64'd0);
    chk("R1", "reset tag0", 64'(disp_tag[0]), 64'd0);
    chk("R1", "reset tag1", 64'(disp_tag[1]), 64'd1);
    cycle();

    // R5: younger address first, nothing leaves until the oldest has one
    cur_req = "R5";
    idle(); wr(1, 1, 16'h1110); cycle();
    idle(); repeat (3) cycle();
    chk("R5", "held acc_vld", 64'(acc_vld), 64'd0);
    cur_req = "R8";
    wr(0, 0, 16'h1000); cycle();
    idle(); repeat (4) cycle();

    // R6: pairing rules
    cur_req = "R6";
    pair_case(1, 0, 1, 0, 16'h2000);
    pair_case(1, 1, 1, 0, 16'h2100);
    pair_case(1, 0, 1, 1, 16'h2200);
    pair_case(0, 0, 1, 1, 16'h2300);
    pair_case(1, 1, 0, 1, 16'h2400);
    pair_case(0, 1, 0, 0, 16'h2500);

    // R4: port priority on the same tag
    cur_req = "R4";
    t = m_tail;
    idle(); disp_req = 2'b01; cycle();
    idle(); wr(0, t, 16'h3AAA); wr(1, t, 16'h3BBB); cycle();
    idle(); repeat (4) cycle();

    // R4: write to a free slot is dropped; new allocation has no address
    t = m_tail;
    idle(); wr(0, t, 16'hDEAD); cycle();
    idle(); disp_req = 2'b01; cycle();
    idle(); repeat (4) cycle();
    chk("R4", "unaddressed slot acc_vld", 64'(acc_vld), 64'd0);
    wr(0, t, 16'h3CCC); cycle();
    idle(); wr(0, t, 16'hBEEF); cycle();
    idle(); repeat (4) cycle();

    // R3: fill to capacity
    cur_req = "R3";
    repeat (5) begin idle(); disp_req = 2'b11; cycle(); end
    idle(); disp_req = 2'b01; cycle();
    idle(); disp_req = 2'b11; cycle();
    idle(); disp_req = 2'b01; cycle();
    idle(); disp_req = 2'b10; cycle();

    // R7: room appears only the cycle after a scan
    cur_req = "R7";
    idle(); wr(0, m_q[0], 16'h4000); cycle();
    idle(); disp_req = 2'b01; cycle();
    idle(); disp_req = 2'b01; cycle();

    // R2: drain with wrap of tags
    cur_req = "R2";
    repeat (16) begin
      idle();
      if (m_q.size() > 0) wr(0, m_q[0], 16'(16'h5000 + m_q[0]));
      if (m_q.size() > 1) wr(1, m_q[1], 16'(16'h5100 + m_q[1]));
      disp_req = 2'b01;
      cycle();
    end
    idle(); repeat (4) cycle();

    // R9: flush while busy, dispatch in the same cycle is dropped
    cur_req = "R9";
    idle(); disp_req = 2'b11; cycle();
    idle(); wr(0, m_q[m_q.size()-2], 16'h6000); wr(1, m_q[m_q.size()-1], 16'h6010);
    disp_req = 2'b11; cycle();
    idle(); cycle();
    idle(); flush = 1'b1; disp_req = 2'b11; cycle();
    idle(); cycle();
    chk("R9", "post-flush acc_vld", 64'(acc_vld), 64'd0);
    disp_req = 2'b11;
    #1;
    chk("R9", "post-flush tag0", 64'(disp_tag[0]), 64'd0);
    cycle();
    idle(); repeat (3) cycle();

    // R10: long mixed traffic
    cur_req = "R10";
    for (int i = 0; i < 800; i++) begin
      idle();
      flush      = (i % 173 == 172);
      disp_req   = 2'($urandom_range(0, 3));
      disp_store = 2'($urandom_range(0, 3));
      disp_is64  = 2'($urandom_range(0, 3));
      for (int p = 0; p < 2; p++) begin
        if ($urandom_range(0, 9) == 0) begin
          wr(p, $urandom_range(0, DEPTH - 1), 16'($urandom));
        end else if ($urandom_range(0, 2) != 0 && m_q.size() > 0) begin
          wr(p, m_q[$urandom_range(0, m_q.size() - 1)], 16'($urandom));
        end
      end
      cycle();
    end
    idle(); repeat (4) cycle();

    summary();
    $finish;
  end

endmodule